// File: doc/BRIEF.md
# Last-Writer History Table

This block remembers, for every word address written by a transaction that has entered speculative validation, the commit ID of the most recent such writer. Hazard detection asks it, one address per cycle, whether a read needs to wait on an earlier writer. The answer is either a commit ID or "nil", meaning no writer is known.

Exact tracking is done by a small fully associative recency table with first-in first-out replacement. When the table is full and a new address arrives, the oldest entry is not lost. It is folded into an approximate two-hash filter. The filter may return a commit ID that is too large for an address it never saw. It never returns nil for an address that was evicted. This keeps the stall decision conservative with a small amount of storage.

A clear input wipes both structures. The surrounding pipeline raises it only when no commit IDs are still in flight. Commit IDs are assumed to increase from one transaction to the next between clears.

Top module: `lwh_table`

## Requirements
- R1: After reset, every lookup answers nil (`rsp_hit`=0), and `rsp_valid` is low until a lookup is requested.
- R2: A lookup presented in one cycle is answered in the next cycle. `rsp_valid`=1, and if the address was inserted earlier and is still held exactly, `rsp_hit`=1 with the last inserted commit ID.
- R3: Inserting an address that the recency table already holds replaces its commit ID in place. It uses no new slot and evicts nothing.
- R4: Once all DEPTH slots hold distinct addresses, inserting a new address evicts the entry placed into a slot earliest. In-place updates do not change this order. The write pointer advances only on new addresses and wraps after DEPTH.
- R5: An evicted entry updates two filter slots, at indices h0 and h1 of its address. Each slot keeps the maximum commit ID folded into it. A lookup that misses the table returns the smaller of the two slots' commit IDs. With I = FILT_IDX_W and word address a, h0 = a[I-1:0] XOR a[2I-1:I], and h1 = a[3I-1:2I] XOR (a[I-1:0] bit-reversed).
- R6: A lookup that misses the table answers nil when either of its two filter slots has never been written since the last reset or clear.
- R7: When an address is held in the recency table, its exact commit ID is returned even if the filter would give a different value.
- R8: When an insert and a lookup of the same address happen in the same cycle, the response carries the commit ID being inserted.
- R9: A clear empties the table and the filter and rewinds the write pointer. An insert in the clear cycle is dropped, and a lookup in the clear cycle answers nil.
- R10: In a cycle with no lookup request, the following cycle has `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Empty table and filter |
| ins_valid | input | 1 | Insert request |
| ins_addr | input | ADDR_W | Word address written |
| ins_cid | input | CID_W | Commit ID of the writer |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Word address read |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | A writer is known |
| rsp_cid | output | CID_W | Commit ID of that writer |

## Verification
The bench builds the block with DEPTH=4, FILT_IDX_W=3 and ADDR_W=16. This way, a fifth distinct insert already forces an eviction. Eight slots per filter bank make many addresses share slots, so the max-fold, the min-select and the empty-slot nil are all reached within a few dozen inserts. A rolling sequence of inserts wraps the pointer several times. This shows that an updated entry still leaves in FIFO order.

// File: rtl/lwh_pkg.sv
// Package: shared types for the last-writer history table.
// Assumes nothing beyond being compiled before the modules that import it.
package lwh_pkg;
    // Where a lookup answer is taken from, in priority order.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_BYPASS = 2'd1,
        SRC_TABLE  = 2'd2,
        SRC_FILTER = 2'd3
    } lwh_src_e;
endpackage

// File: rtl/lwh_recency.sv
// Module: exact recency table. It holds up to DEPTH (address, commit ID) pairs
// and replaces them in FIFO order. Re-insert updates in place. A new address
// written over an occupied slot reports that slot's old contents as an eviction.
// Assumes the caller gates ins_en with clr.
module lwh_recency #(
    parameter int ADDR_W = 30,
    parameter int CID_W  = 10,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ins_en,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [CID_W-1:0]  ins_cid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [CID_W-1:0]  lk_cid,
    output logic              ev_valid,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [CID_W-1:0]  ev_cid
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DEPTH-1:0]  ent_v;
    logic [ADDR_W-1:0] ent_a [DEPTH];
    logic [CID_W-1:0]  ent_c [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;

    logic [DEPTH-1:0]  ins_match;
    logic [DEPTH-1:0]  lk_match;
    logic              ins_hit;
    logic [PTR_W-1:0]  ins_idx;

    // Compare both request addresses against every valid slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign ins_match[g] = ent_v[g] && (ent_a[g] == ins_addr);
        assign lk_match[g]  = ent_v[g] && (ent_a[g] == lk_addr);
    end

    // Encode the insert match and OR-reduce the lookup commit ID.
    always_comb begin
        ins_hit = |ins_match;
        ins_idx = '0;
        lk_hit  = |lk_match;
        lk_cid  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ins_match[i]) ins_idx = PTR_W'(i);
            if (lk_match[i])  lk_cid  = lk_cid | ent_c[i];
        end
    end

    // An insert of a new address over an occupied slot pushes that slot out.
    always_comb begin
        ev_valid = ins_en && !ins_hit && ent_v[wr_ptr];
        ev_addr  = ent_a[wr_ptr];
        ev_cid   = ent_c[wr_ptr];
    end

    // Slot storage and FIFO pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ent_v  <= '0;
            wr_ptr <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_a[i] <= '0;
                ent_c[i] <= '0;
            end
        end else if (ins_en) begin
            if (ins_hit) begin
                ent_c[ins_idx] <= ins_cid;
            end else begin
                ent_v[wr_ptr] <= 1'b1;
                ent_a[wr_ptr] <= ins_addr;
                ent_c[wr_ptr] <= ins_cid;
                wr_ptr        <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
        end
    end

    AST_ONE_SLOT_PER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ins_match)); // R3
    AST_UPDATE_NO_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && ins_hit) |-> !ev_valid); // R3
    AST_CLEAR_EMPTIES_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ($countones(ent_v) == 0)); // R9
    AST_EVICT_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (&ent_v)); // R4
endmodule

// File: rtl/lwh_filter.sv
// Module: approximate store for evicted entries. It has two banks of 2**IDX_W
// slots. Each bank is indexed by its own hash of the address. A slot keeps the
// largest commit ID folded into it. A lookup answers the smaller of its two
// slots, or nil if either slot is empty. Assumes ADDR_W >= 3*IDX_W.
module lwh_filter #(
    parameter int ADDR_W = 30,
    parameter int CID_W  = 10,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [CID_W-1:0]  upd_cid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [CID_W-1:0]  lk_cid
);
    localparam int SLOTS = 1 << IDX_W;

    // First index: low field folded with the next field.
    function automatic logic [IDX_W-1:0] hash_a(input logic [ADDR_W-1:0] a);
        return a[IDX_W-1:0] ^ a[2*IDX_W-1:IDX_W];
    endfunction

    // Second index: third field folded with the low field bit-reversed.
    function automatic logic [IDX_W-1:0] hash_b(input logic [ADDR_W-1:0] a);
        logic [IDX_W-1:0] r;
        for (int k = 0; k < IDX_W; k++) r[k] = a[IDX_W-1-k];
        return a[3*IDX_W-1:2*IDX_W] ^ r;
    endfunction

    logic [SLOTS-1:0] b0_v, b1_v;
    logic [CID_W-1:0] b0_c [SLOTS];
    logic [CID_W-1:0] b1_c [SLOTS];

    logic [IDX_W-1:0] u0, u1, l0, l1;

    // Hash both request addresses.
    always_comb begin
        u0 = hash_a(upd_addr);
        u1 = hash_b(upd_addr);
        l0 = hash_a(lk_addr);
        l1 = hash_b(lk_addr);
    end

    // Lookup: both slots must be filled, and the smaller ID is the answer.
    always_comb begin
        lk_hit = b0_v[l0] && b1_v[l1];
        lk_cid = (b0_c[l0] < b1_c[l1]) ? b0_c[l0] : b1_c[l1];
    end

    // Fold an evicted entry into both banks, keeping the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            b0_v <= '0;
            b1_v <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                b0_c[i] <= '0;
                b1_c[i] <= '0;
            end
        end else if (upd_en) begin
            b0_v[u0] <= 1'b1;
            b1_v[u1] <= 1'b1;
            if (!b0_v[u0] || upd_cid > b0_c[u0]) b0_c[u0] <= upd_cid;
            if (!b1_v[u1] || upd_cid > b1_c[u1]) b1_c[u1] <= upd_cid;
        end
    end

    AST_FILTER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (b0_v == '0 && b1_v == '0)); // R9
    AST_UPDATE_FILLS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !clr) |=> (b0_v[$past(u0)] && b1_v[$past(u1)])); // R5
    for (genvar g = 0; g < SLOTS; g++) begin : g_mono
        AST_SLOT_NEVER_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && b0_v[g]) |=> (b0_c[g] >= $past(b0_c[g]))); // R5
    end
endmodule

// File: rtl/lwh_table.sv
// Module: last-writer history table top. It combines the exact recency table,
// the eviction filter and a same-cycle insert bypass into one registered lookup
// answer. Assumes commit IDs increase between clears, and that clr is raised
// only when no commit IDs are in flight.
module lwh_table
    import lwh_pkg::*;
#(
    parameter int ADDR_W     = 30,
    parameter int CID_W      = 10,
    parameter int DEPTH      = 16,
    parameter int FILT_IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [CID_W-1:0]  ins_cid,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [CID_W-1:0]  rsp_cid
);
    logic              ins_en;
    logic              tab_hit, flt_hit, ev_valid;
    logic [CID_W-1:0]  tab_cid, flt_cid, ev_cid;
    logic [ADDR_W-1:0] ev_addr;
    lwh_src_e          src;

    // Inserts are dropped in a clear cycle.
    assign ins_en = ins_valid && !clr;

    lwh_recency #(.ADDR_W(ADDR_W), .CID_W(CID_W), .DEPTH(DEPTH)) u_recency (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .ins_en(ins_en), .ins_addr(ins_addr), .ins_cid(ins_cid),
        .lk_addr(lk_addr), .lk_hit(tab_hit), .lk_cid(tab_cid),
        .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_cid(ev_cid)
    );

    lwh_filter #(.ADDR_W(ADDR_W), .CID_W(CID_W), .IDX_W(FILT_IDX_W)) u_filter (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .upd_en(ev_valid), .upd_addr(ev_addr), .upd_cid(ev_cid),
        .lk_addr(lk_addr), .lk_hit(flt_hit), .lk_cid(flt_cid)
    );

    // Pick the answer source: bypass, then exact table, then filter.
    always_comb begin
        if (clr)                                 src = SRC_NONE;
        else if (ins_valid && ins_addr == lk_addr) src = SRC_BYPASS;
        else if (tab_hit)                        src = SRC_TABLE;
        else if (flt_hit)                        src = SRC_FILTER;
        else                                     src = SRC_NONE;
    end

    // Register the answer, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_cid   <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && (src != SRC_NONE);
            unique case (src)
                SRC_BYPASS: rsp_cid <= ins_cid;
                SRC_TABLE:  rsp_cid <= tab_cid;
                SRC_FILTER: rsp_cid <= flt_cid;
                default:    rsp_cid <= '0;
            endcase
        end
    end

    initial AST_FILTER_FITS_ADDR: assert (ADDR_W >= 3 * FILT_IDX_W); // R5

    AST_ANSWER_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid); // R2
    AST_QUIET_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid); // R10
    AST_SAME_CYCLE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && ins_valid && !clr && ins_addr == lk_addr)
            |=> (rsp_hit && rsp_cid == $past(ins_cid))); // R8
    AST_CLEAR_ANSWERS_NIL: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && clr) |=> !rsp_hit); // R9
    AST_TABLE_OVER_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !clr && !ins_valid && tab_hit) |=> (rsp_cid == $past(tab_cid))); // R7
endmodule

// File: tb/lwh_table_bench.sv
module lwh_table_bench;
    localparam int AW = 16;
    localparam int CW = 8;
    localparam int DP = 4;
    localparam int IW = 3;
    localparam int NS = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          ins_valid = 1'b0;
    logic [AW-1:0] ins_addr = '0;
    logic [CW-1:0] ins_cid = '0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          rsp_valid, rsp_hit;
    logic [CW-1:0] rsp_cid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    lwh_table #(.ADDR_W(AW), .CID_W(CW), .DEPTH(DP), .FILT_IDX_W(IW)) u_lwh_table (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_cid(ins_cid),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_cid(rsp_cid)
    );

    typedef struct {
        bit          v;
        bit          hit;
        logic [CW-1:0] cid;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    // Reference state built from the requirements.
    bit          m_v [DP];
    logic [AW-1:0] m_a [DP];
    logic [CW-1:0] m_c [DP];
    int          m_ptr = 0;
    bit          f0_v [NS];
    bit          f1_v [NS];
    logic [CW-1:0] f0_c [NS];
    logic [CW-1:0] f1_c [NS];

    function automatic int h0(input logic [AW-1:0] a);
        return int'(a[2:0] ^ a[5:3]);
    endfunction
    function automatic int h1(input logic [AW-1:0] a);
        return int'(a[8:6] ^ {a[0], a[1], a[2]});
    endfunction

    task automatic model_clear();
        for (int i = 0; i < DP; i++) m_v[i] = 1'b0;
        for (int i = 0; i < NS; i++) begin f0_v[i] = 1'b0; f1_v[i] = 1'b0; end
        m_ptr = 0;
    endtask

    task automatic check(input bit ok, input string tag, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // Driver: one cycle of stimulus. Expectation is pushed, then the model is updated.
    task automatic op(input bit ins, input logic [AW-1:0] ia, input logic [CW-1:0] ic,
                      input bit lk, input logic [AW-1:0] la, input bit c, input string tag);
        exp_t e;
        int   found;
        @(negedge clk);
        ins_valid = ins; ins_addr = ia; ins_cid = ic;
        lk_valid = lk; lk_addr = la; clr = c;
        e.v = lk; e.hit = 1'b0; e.cid = '0; e.tag = tag;
        if (lk && !c) begin
            found = -1;
            for (int i = 0; i < DP; i++) if (m_v[i] && m_a[i] == la) found = i;
            if (ins && ia == la) begin e.hit = 1'b1; e.cid = ic; end
            else if (found >= 0) begin e.hit = 1'b1; e.cid = m_c[found]; end
            else if (f0_v[h0(la)] && f1_v[h1(la)]) begin
                e.hit = 1'b1;
                e.cid = (f0_c[h0(la)] < f1_c[h1(la)]) ? f0_c[h0(la)] : f1_c[h1(la)];
            end
        end
        exp_q.push_back(e);
        if (c) model_clear();
        else if (ins) begin
            found = -1;
            for (int i = 0; i < DP; i++) if (m_v[i] && m_a[i] == ia) found = i;
            if (found >= 0) m_c[found] = ic;
            else begin
                if (m_v[m_ptr]) begin
                    if (!f0_v[h0(m_a[m_ptr])] || m_c[m_ptr] > f0_c[h0(m_a[m_ptr])])
                        f0_c[h0(m_a[m_ptr])] = m_c[m_ptr];
                    if (!f1_v[h1(m_a[m_ptr])] || m_c[m_ptr] > f1_c[h1(m_a[m_ptr])])
                        f1_c[h1(m_a[m_ptr])] = m_c[m_ptr];
                    f0_v[h0(m_a[m_ptr])] = 1'b1;
                    f1_v[h1(m_a[m_ptr])] = 1'b1;
                end
                m_v[m_ptr] = 1'b1; m_a[m_ptr] = ia; m_c[m_ptr] = ic;
                m_ptr = (m_ptr + 1) % DP;
            end
        end
    endtask

    task automatic look(input logic [AW-1:0] la, input string tag);
        op(1'b0, '0, '0, 1'b1, la, 1'b0, tag);
    endtask
    task automatic put(input logic [AW-1:0] ia, input logic [CW-1:0] ic, input string tag);
        op(1'b1, ia, ic, 1'b0, '0, 1'b0, tag);
    endtask

    // Monitor: pops one expectation per cycle after each edge that follows stimulus.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_valid == e.v, e.tag,
                      $sformatf("rsp_valid actual %0b expected %0b", rsp_valid, e.v));
                if (e.v)
                    check(rsp_hit == e.hit && (!e.hit || rsp_cid == e.cid), e.tag,
                          $sformatf("hit/cid actual %0b/%0d expected %0b/%0d",
                                    rsp_hit, rsp_cid, e.hit, e.cid));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(rsp_valid == 1'b0, "R1", $sformatf("rsp_valid actual %0b expected 0", rsp_valid));
        look(16'h0011, "R1");
        look(16'h1234, "R1");
        // R2: insert then lookup
        put(16'h0011, 8'd5, "R2");
        look(16'h0011, "R2");
        // R10: no request, no answer
        op(1'b0, '0, '0, 1'b0, '0, 1'b0, "R10");
        // R8: same-cycle insert and lookup
        op(1'b1, 16'h0022, 8'd7, 1'b1, 16'h0022, 1'b0, "R8");
        // R3: re-insert updates in place, then fill the table
        put(16'h0011, 8'd9, "R3");
        put(16'h0033, 8'd10, "R3");
        put(16'h0044, 8'd11, "R3");
        look(16'h0011, "R3");
        look(16'h0022, "R3");
        look(16'h0033, "R3");
        look(16'h0044, "R3");
        // R4: a fifth address evicts the earliest slot (0x0011 despite its update)
        put(16'h0055, 8'd12, "R4");
        look(16'h0022, "R4");
        look(16'h0055, "R4");
        // R5: evicted address answered from the filter
        look(16'h0011, "R5");
        // R6: shares h0 with 0x0011, its h1 slot is empty
        look(16'h0003, "R6");
        // R7: back into the table with a new ID; exact value wins over the filter
        put(16'h0011, 8'd20, "R7");
        look(16'h0011, "R7");
        // R5 and R4: rolling inserts wrap the pointer and fill the filter
        for (int i = 0; i < 40; i++) begin
            op(1'b1, 16'(i * 37 + 5), 8'(30 + i), 1'b1, 16'(i * 53), 1'b0, "R5");
        end
        for (int i = 0; i < 24; i++) look(16'(i * 37 + 5), "R4");
        for (int i = 0; i < 16; i++) look(16'(i * 11 + 1), "R6");
        // R9: clear with a concurrent insert and lookup
        op(1'b1, 16'h0777, 8'd99, 1'b1, 16'h0011, 1'b1, "R9");
        look(16'h0777, "R9");
        look(16'h0055, "R9");
        look(16'(39 * 37 + 5), "R9");
        // R2 after clear: pointer rewound, table usable again
        put(16'h0101, 8'd3, "R2");
        look(16'h0101, "R2");
        op(1'b0, '0, '0, 1'b0, '0, 1'b0, "R10");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule